// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block keeps the fetch address of a small word-addressed processor and works out the next one. Each time the core advances by one instruction it raises a step strobe for one clock, and the block looks at the instruction word and a five-bit status word. It then does one of three things:

- moves the counter to the next word;
- loads an absolute 12-bit target when a branch condition holds;
- stops for good when it sees the stop opcode.

Once stopped, the block shows a halted flag and ignores all further steps until reset. Fetch memory, arithmetic and the register file are outside this block. The only sequential state is the counter and the halted bit. Results appear on the clock edge that samples the strobe.

Top module: `pcb_unit`

## Requirements
- R1: While reset is high, and after the first clock edge that samples it, `pcAddr` is 0 and `haltedFlag` is 0.
- R2: On an edge with `stepStrobe` high and the unit not halted, an opcode (bits 31:28) other than 1 and 14 (this covers no-operation, opcode 0) sets `pcAddr` to its previous value plus 1. On an edge with `stepStrobe` low, `pcAddr` and `haltedFlag` keep their values whatever the instruction and status inputs carry.
- R3: A stepped instruction with opcode 1 and condition field (bits 27:24) equal to 0 loads `pcAddr` with instruction bits 11:0.
- R4: For opcode 1 with condition 1, 2, 3, 4 or 5, the branch tests status bit 0 (carry), bit 1 (even), bit 2 (odd parity), bit 3 (zero) or bit 4 (negative) respectively. If that bit is 1, `pcAddr` takes instruction bits 11:0. If it is 0, `pcAddr` advances by 1.
- R5: For opcode 1 with condition values 6 to 15, the branch is never taken and `pcAddr` advances by 1, whatever the status word holds.
- R6: A stepped instruction with opcode 14 sets `haltedFlag` after that edge and leaves `pcAddr` at the address of that instruction. `haltedFlag` then stays 1 until reset.
- R7: While `haltedFlag` is 1, step strobes have no effect. `pcAddr` and `haltedFlag` stay the same for every instruction, branches included.
- R8: Advancing from address 4095 gives address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stepStrobe | input | 1 | One-cycle pulse that commits the current instruction |
| instrWord | input | 32 | Instruction being committed |
| statusFlags | input | 5 | Status word: bit 4 negative, 3 zero, 2 parity, 1 even, 0 carry |
| pcAddr | output | 12 | Current fetch address |
| haltedFlag | output | 1 | High once the stop opcode has been committed |

## Verification
Two functions can fall in the same cycle: the branch decision and the counter's wrap at the top of the address space. The bench provokes this in two ways. It jumps to address 4095 and then steps an untaken branch there, which must wrap to 0. It also steps a taken branch at 4095, which must land on its target, not on 0. A second overlap occurs when a branch, or another stop, is stepped while already halted. The bench judges these against a next-state function of its own, for directed cases and for several thousand random steps with random status words and occasional resets.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int unsigned OPC_W  = 4;
  localparam int unsigned COND_W = 4;

  localparam logic [OPC_W-1:0] OPC_IDLE = 4'h0;
  localparam logic [OPC_W-1:0] OPC_JUMP = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STOP = 4'hE;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic load;   // take the branch target
    logic incr;   // move to the next word
  } pcCmd_t;

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
  import pcb_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned FLAG_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stepStrobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [FLAG_W-1:0]  statusFlags,
  output pcCmd_t             pcCmd,
  output logic               haltedQ
);

  localparam int unsigned COND_N  = 2 ** COND_W;
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned CC_LSB  = OPC_LSB - COND_W;

  logic [OPC_W-1:0]  opField;
  logic [COND_W-1:0] ccField;
  logic [COND_N-1:0] condVec;
  logic              unusedLow;
  logic              active;
  logic              isJump;
  logic              isStop;
  logic              condMet;

  assign opField   = instrWord[INSTR_W-1:OPC_LSB];
  assign ccField   = instrWord[OPC_LSB-1:CC_LSB];
  assign unusedLow = ^instrWord[CC_LSB-1:0];

  // Entry 0 is always true; entry k tests status bit k-1; the rest never hold
  genvar k;
  generate
    for (k = 0; k < COND_N; k++) begin : g_cond
      if (k == 0) begin : g_always
        assign condVec[k] = 1'b1;
      end else if (k <= FLAG_W) begin : g_flag
        assign condVec[k] = statusFlags[k-1];
      end else begin : g_never
        assign condVec[k] = 1'b0;
      end
    end
  endgenerate

  assign active  = stepStrobe && !haltedQ;
  assign isJump  = (opField == OPC_JUMP);
  assign isStop  = (opField == OPC_STOP);
  assign condMet = condVec[ccField];

  always_comb begin
    pcCmd      = '0;
    pcCmd.load = active && isJump && condMet;
    pcCmd.incr = active && !isStop && !(isJump && condMet);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      haltedQ <= 1'b0;
    end else if (active && isStop) begin
      haltedQ <= 1'b1;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltedQ |=> haltedQ); // R6

  AST_HALT_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    haltedQ |-> (pcCmd == '0)); // R7

endmodule

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  pcCmd_t            pcCmd,
  input  logic [ADDR_W-1:0] jumpTarget,
  output logic [ADDR_W-1:0] pcQ
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    pcNext = pcQ;
    if (pcCmd.load) begin
      pcNext = jumpTarget;
    end else if (pcCmd.incr) begin
      pcNext = pcQ + ADDR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0;
    end else begin
      pcQ <= pcNext;
    end
  end

  AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (rst)
    pcCmd.load |=> (pcQ == $past(jumpTarget))); // R3

endmodule

// File: rtl/pcb_unit.sv
module pcb_unit
  import pcb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned FLAG_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stepStrobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [FLAG_W-1:0]  statusFlags,
  output logic [ADDR_W-1:0]  pcAddr,
  output logic               haltedFlag
);

  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned CC_LSB  = OPC_LSB - COND_W;

  pcCmd_t pcCmd;

  pcb_ctrl #(
    .INSTR_W(INSTR_W),
    .FLAG_W (FLAG_W)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stepStrobe (stepStrobe),
    .instrWord  (instrWord),
    .statusFlags(statusFlags),
    .pcCmd      (pcCmd),
    .haltedQ    (haltedFlag)
  );

  pcb_datapath #(
    .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .pcCmd     (pcCmd),
    .jumpTarget(instrWord[ADDR_W-1:0]),
    .pcQ       (pcAddr)
  );

  logic [OPC_W-1:0]  opSeen;
  logic [COND_W-1:0] ccSeen;
  logic              liveStep;

  assign opSeen   = instrWord[INSTR_W-1:OPC_LSB];
  assign ccSeen   = instrWord[OPC_LSB-1:CC_LSB];
  assign liveStep = stepStrobe && !haltedFlag;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pcAddr == '0) && !haltedFlag); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stepStrobe |=> $stable(pcAddr) && $stable(haltedFlag)); // R2

  AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (liveStep && opSeen != OPC_JUMP && opSeen != OPC_STOP)
      |=> (pcAddr == $past(pcAddr) + ADDR_W'(1))); // R2

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (liveStep && opSeen == OPC_JUMP && ccSeen == '0)
      |=> (pcAddr == $past(instrWord[ADDR_W-1:0]))); // R3

  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (liveStep && opSeen == OPC_JUMP && ccSeen > COND_W'(FLAG_W))
      |=> (pcAddr == $past(pcAddr) + ADDR_W'(1))); // R5

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (liveStep && opSeen == OPC_STOP) |=> haltedFlag && $stable(pcAddr)); // R6

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    haltedFlag |=> $stable(pcAddr)); // R7

endmodule

// File: tb/test_pcb_unit.sv
module test_pcb_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stepStrobe = 1'b0;
  logic [31:0] instrWord = '0;
  logic [4:0]  statusFlags = '0;
  logic [11:0] pcAddr;
  logic        haltedFlag;

  int unsigned checkCount = 0;
  int unsigned failCount  = 0;
  logic [11:0] expPc = '0;
  logic        expHalt = 1'b0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  pcb_unit i_pcb_unit (
    .clk        (clk),
    .rst        (rst),
    .stepStrobe (stepStrobe),
    .instrWord  (instrWord),
    .statusFlags(statusFlags),
    .pcAddr     (pcAddr),
    .haltedFlag (haltedFlag)
  );

  function automatic logic [31:0] mkInstr(logic [3:0] op, logic [3:0] cc, logic [11:0] tgt);
    return {op, cc, 12'($urandom), tgt};
  endfunction

  // Independent next-state model: {halt, pc}
  function automatic logic [12:0] modelNext(logic [11:0] pc, logic hlt, logic stp,
                                            logic [31:0] ins, logic [4:0] st);
    logic [3:0] op;
    logic [3:0] cc;
    logic       take;
    op = ins[31:28];
    cc = ins[27:24];
    if (!stp || hlt) return {hlt, pc};
    if (op == 4'hE) return {1'b1, pc};
    if (op == 4'h1) begin
      case (cc)
        4'd0: take = 1'b1;
        4'd1: take = st[0];
        4'd2: take = st[1];
        4'd3: take = st[2];
        4'd4: take = st[3];
        4'd5: take = st[4];
        default: take = 1'b0;
      endcase
      if (take) return {1'b0, ins[11:0]};
    end
    return {1'b0, pc + 12'd1};
  endfunction

  task automatic compare(string req);
    checkCount++;
    if (pcAddr !== expPc || haltedFlag !== expHalt) begin
      failCount++;
      $display("FAIL %s: pc=%0d halted=%0b expected pc=%0d halted=%0b",
               req, pcAddr, haltedFlag, expPc, expHalt);
    end
  endtask

  task automatic doReset(string req);
    @(negedge clk);
    rst = 1'b1;
    stepStrobe = 1'b0;
    @(negedge clk);
    expPc = '0;
    expHalt = 1'b0;
    compare(req);
    rst = 1'b0;
  endtask

  task automatic apply(logic stp, logic [31:0] ins, logic [4:0] st, string req);
    logic [12:0] nxt;
    stepStrobe  = stp;
    instrWord   = ins;
    statusFlags = st;
    nxt = modelNext(expPc, expHalt, stp, ins, st);
    @(negedge clk);
    {expHalt, expPc} = nxt;
    compare(req);
  endtask

  function automatic string tagFor(logic stp, logic hlt, logic [31:0] ins);
    if (!stp) return "R2 idle";
    if (hlt) return "R7 halted step";
    if (ins[31:28] == 4'hE) return "R6 stop";
    if (ins[31:28] != 4'h1) return "R2 advance";
    if (ins[27:24] == 4'd0) return "R3 always";
    if (ins[27:24] <= 4'd5) return "R4 flag";
    return "R5 never";
  endfunction

  initial begin
    void'($urandom(32'h1234_5EED));
    @(negedge clk);
    doReset("R1 reset");
    checkCount++;
    if (pcAddr !== 12'd0 || haltedFlag !== 1'b0) begin
      failCount++;
      $display("FAIL R1: pc=%0d halted=%0b expected pc=0 halted=0", pcAddr, haltedFlag);
    end

    apply(1'b1, mkInstr(4'h0, 4'h0, 12'hABC), 5'h00, "R2 nop advance");
    apply(1'b1, mkInstr(4'h4, 4'h8, 12'h123), 5'h1F, "R2 other op advance");
    apply(1'b0, mkInstr(4'h1, 4'h0, 12'h777), 5'h1F, "R2 no step ignores branch");
    apply(1'b1, mkInstr(4'h1, 4'h0, 12'h345), 5'h00, "R3 always taken");
    for (int c = 1; c <= 5; c++) begin
      apply(1'b1, mkInstr(4'h1, 4'(c), 12'(100 * c)), 5'(1 << (c - 1)), "R4 flag set");
      apply(1'b1, mkInstr(4'h1, 4'(c), 12'hFEE), 5'h1F & ~5'(1 << (c - 1)), "R4 flag clear");
    end
    for (int c = 6; c <= 15; c++) begin
      apply(1'b1, mkInstr(4'h1, 4'(c), 12'h055), 5'h1F, "R5 never taken");
    end
    // Wrap and branch meeting at the top address
    apply(1'b1, mkInstr(4'h1, 4'h0, 12'hFFF), 5'h00, "R3 jump to top");
    apply(1'b1, mkInstr(4'h1, 4'h4, 12'h321), 5'h00, "R8 untaken branch wraps");
    apply(1'b1, mkInstr(4'h1, 4'h0, 12'hFFF), 5'h00, "R3 jump to top");
    apply(1'b1, mkInstr(4'h1, 4'h1, 12'h0AA), 5'h01, "R8 taken branch at top");
    apply(1'b1, mkInstr(4'h1, 4'h0, 12'hFFF), 5'h00, "R3 jump to top");
    apply(1'b1, mkInstr(4'h0, 4'h0, 12'h000), 5'h00, "R8 nop wraps");
    // Stop and frozen state
    apply(1'b1, mkInstr(4'hE, 4'h0, 12'h111), 5'h00, "R6 stop");
    apply(1'b1, mkInstr(4'h1, 4'h0, 12'h222), 5'h1F, "R7 branch while halted");
    apply(1'b1, mkInstr(4'h0, 4'h0, 12'h000), 5'h00, "R7 nop while halted");
    apply(1'b1, mkInstr(4'hE, 4'h0, 12'h000), 5'h00, "R7 stop while halted");
    apply(1'b0, mkInstr(4'h1, 4'h0, 12'h333), 5'h00, "R6 halt sticky");
    doReset("R1 reset after halt");

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  op;
      logic [3:0]  cc;
      logic        stp;
      logic [31:0] ins;
      if (expHalt && ($urandom % 8 == 0)) begin
        doReset("R1 random reset");
      end else begin
        case ($urandom % 8)
          0, 1, 2: op = 4'h1;
          3:       op = ($urandom % 6 == 0) ? 4'hE : 4'h0;
          default: op = 4'($urandom);
        endcase
        if (op == 4'hE && ($urandom % 3 != 0)) op = 4'h0;
        cc  = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 6);
        stp = ($urandom % 4) != 0;
        ins = ($urandom % 16 == 0) ? mkInstr(op, cc, 12'hFFF) : mkInstr(op, cc, 12'($urandom));
        apply(stp, ins, 5'($urandom), tagFor(stp, expHalt, ins));
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

endmodule